// File: doc/BRIEF.md
# Reset Qualifier and Startup Sequencer

This block sits between the raw active-low reset pin of a small CPU core and the core itself. It filters the pin so that a short low pulse cannot stop the core. Once the pin has been low for two sampled clock edges in a row, the core is held. When the pin returns high, the block runs a fixed startup routine before it lets the core go.

The startup routine is six cycles long. In its fourth cycle the block strobes the core's flag logic, so that interrupts become masked and decimal arithmetic is switched off. In the fifth and sixth cycles it reads the restart vector from memory through a combinational read port, low byte first. In the sixth cycle it loads the assembled address into the program counter. The halt output drops in the cycle after that load.

At power-up the block starts in the held state, as though the pin had been low. It waits for the first rising edge.

Top module: `reset_sequencer`

## Requirements
- R1: From any state, when `rst_pin_n` is sampled low at two consecutive rising clock edges, `halt` is 1 from the second of those edges onward, until a new startup routine completes.
- R2: While the core runs (`halt` = 0), a low on `rst_pin_n` that is sampled at only one edge leaves `halt` at 0 and produces no strobe, read or load.
- R3: During the startup routine, a low on `rst_pin_n` sampled at only one edge neither restarts nor delays the routine: every output event keeps the timing it would have had without the glitch.
- R4: While held, the first edge at which `rst_pin_n` is sampled high after having been sampled low starts the routine. Let E be that edge. The routine's states follow edges E through E+5, and `halt` stays 1 throughout.
- R5: `set_irq_mask` and `clr_dec_mode` are both 1 for exactly one cycle, the fourth of the routine (the state after edge E+3). They are 0 at all other times.
- R6: `mem_rd` is 1 only in the fifth cycle of the routine, with `mem_addr` = VEC_LO (16'h7FFC), and in the sixth cycle, with `mem_addr` = VEC_LO+1 (16'h7FFD). In the sixth cycle `pc_load` is 1 and `pc_value` = {byte read at VEC_LO+1, byte read at VEC_LO}.
- R7: `halt` goes to 0 in the cycle after the one in which `pc_load` was 1, and stays 0 while the pin remains high.
- R8: If `rst_pin_n` is sampled low at two consecutive edges during the routine, the routine is abandoned: no later strobe, read or load occurs and `halt` stays 1. A later rising edge starts the full routine from its first cycle.
- R9: From power-up, `halt` is 1 and no strobe, read or load occurs until the first rising edge of `rst_pin_n` has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Raw active-low reset pin, sampled on rising edges |
| halt | output | 1 | Holds the core while 1 |
| set_irq_mask | output | 1 | One-cycle strobe that sets the interrupt-mask flag |
| clr_dec_mode | output | 1 | One-cycle strobe that clears the decimal-mode flag |
| mem_rd | output | 1 | Vector read request |
| mem_addr | output | 16 | Vector read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_addr` |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 16 | Restart address to load into the program counter |

## Verification
The bench drives single-cycle glitches in two places: while the core runs, where a filter that reacts too early would halt the core, and inside the startup routine, where a design that treats the returning high as a new rising edge would restart the routine and shift every event later. It also aborts the routine with a two-cycle low just before the flag strobes are due. A design that forgets the abort would still strobe, read or load, and one that keeps stale step state would restart out of phase. The two vector bytes are loaded with distinct values, so a swapped byte order or a read of the wrong address appears in the loaded value. The release of `halt` is timed against the load, which exposes a release one cycle early or late.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int DATA_W  = 8,
  parameter int SEQ_LEN = 6,
  parameter logic [2*DATA_W-1:0] VEC_LO = 16'h7FFC
) (
  input  logic                clk,
  input  logic                rst_pin_n,
  output logic                halt,
  output logic                set_irq_mask,
  output logic                clr_dec_mode,
  output logic                mem_rd,
  output logic [2*DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value
);
  localparam int CNT_W = $clog2(SEQ_LEN);
  localparam logic [CNT_W-1:0] FLAG_STEP = CNT_W'(SEQ_LEN - 3);
  localparam logic [CNT_W-1:0] LO_STEP   = CNT_W'(SEQ_LEN - 2);
  localparam logic [CNT_W-1:0] HI_STEP   = CNT_W'(SEQ_LEN - 1);

  typedef enum logic [1:0] {HELD, BOOT, RUN} state_t;

  state_t            state    = HELD;
  logic [CNT_W-1:0]  step     = '0;
  logic              pin_prev = 1'b0;
  logic [DATA_W-1:0] lo_q     = '0;

  wire low_twice  = !rst_pin_n && !pin_prev;
  wire rise       = rst_pin_n && !pin_prev;
  wire in_boot    = (state == BOOT);
  wire at_lo      = in_boot && (step == LO_STEP);
  wire at_hi      = in_boot && (step == HI_STEP);

  always_ff @(posedge clk) begin
    pin_prev <= rst_pin_n;
    if (low_twice) begin
      state <= HELD;
    end else begin
      case (state)
        HELD: if (rise) begin
          state <= BOOT;
          step  <= '0;
        end
        BOOT: if (step == HI_STEP) state <= RUN;
              else step <= step + 1'b1;
        default: state <= RUN;
      endcase
    end
    if (at_lo) lo_q <= mem_rdata;
  end

  assign halt         = (state != RUN);
  assign set_irq_mask = in_boot && (step == FLAG_STEP);
  assign clr_dec_mode = set_irq_mask;
  assign mem_rd       = at_lo || at_hi;
  assign mem_addr     = at_hi ? VEC_LO + 1'b1 : VEC_LO;
  assign pc_load      = at_hi;
  assign pc_value     = {mem_rdata, lo_q};

  // Warm-up counter: keeps $past-based checks quiet until history exists.
  logic [1:0] age = '0;
  always_ff @(posedge clk) if (age != 2'd2) age <= age + 1'b1;
  wire warm = (age == 2'd2);

  assert_halt_after_two_low_R1: assert property (@(posedge clk) disable iff (!warm)
    (!rst_pin_n && !$past(rst_pin_n)) |=> halt);

  assert_halt_during_boot_R4: assert property (@(posedge clk) disable iff (!warm)
    (set_irq_mask || mem_rd) |-> halt);

  assert_flags_before_load_R5: assert property (@(posedge clk) disable iff (!warm)
    pc_load |-> $past(set_irq_mask, 2));

  assert_low_byte_first_R6: assert property (@(posedge clk) disable iff (!warm)
    (mem_rd && mem_addr == VEC_LO + 1'b1) |-> ($past(mem_rd) && $past(mem_addr) == VEC_LO));

  assert_release_after_load_R7: assert property (@(posedge clk) disable iff (!warm)
    $fell(halt) |-> $past(pc_load));
endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
  localparam logic [15:0] VLO = 16'h7FFC;
  localparam logic [7:0] K_HALT = 8'd1, K_FLAG = 8'd2, K_READ = 8'd3, K_LOAD = 8'd4, K_RUN = 8'd5;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic halt, set_irq_mask, clr_dec_mode, mem_rd, pc_load;
  logic [15:0] mem_addr, pc_value;
  logic [7:0] mem_rdata;
  logic [7:0] vec_lo_byte = 8'h34, vec_hi_byte = 8'h12;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [63:0] expq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    if (mem_addr == VLO) mem_rdata = vec_lo_byte;
    else if (mem_addr == VLO + 16'd1) mem_rdata = vec_hi_byte;
    else mem_rdata = 8'hEE;
  end

  reset_sequencer uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .halt(halt),
    .set_irq_mask(set_irq_mask), .clr_dec_mode(clr_dec_mode),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pc_load(pc_load), .pc_value(pc_value)
  );

  function automatic string req_of(logic [7:0] k);
    case (k)
      K_HALT: return "R1";
      K_FLAG: return "R5";
      K_READ: return "R6";
      K_LOAD: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic void expect_ev(logic [7:0] k, int c, logic [15:0] v);
    expq.push_back({k, 24'(c), 16'h0, v});
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: turns observed output events into items and matches them.
  task automatic take(logic [7:0] k, logic [15:0] v);
    logic [63:0] e;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event kind %0d at cycle %0d: actual %0h expected none",
               req_of(k), k, cyc, v);
    end else begin
      e = expq.pop_front();
      if (e[63:56] != k || int'(e[55:32]) != cyc || e[15:0] != v) begin
        errors++;
        $display("FAIL %s event: actual kind %0d cyc %0d val %0h expected kind %0d cyc %0d val %0h",
                 req_of(k), k, cyc, v, e[63:56], e[55:32], e[15:0]);
      end
    end
  endtask

  logic prev_halt = 1'b1;
  always @(negedge clk) begin
    if (halt && !prev_halt) take(K_HALT, 16'h0);
    if (set_irq_mask || clr_dec_mode) take(K_FLAG, {14'h0, set_irq_mask, clr_dec_mode});
    if (mem_rd) take(K_READ, mem_addr);
    if (pc_load) take(K_LOAD, pc_value);
    if (!halt && prev_halt) take(K_RUN, 16'h0);
    prev_halt = halt;
  end

  task automatic drive(bit v);
    @(negedge clk);
    rst_pin_n = v;
  endtask

  task automatic expect_boot(int c, logic [7:0] lo, logic [7:0] hi);
    expect_ev(K_FLAG, c + 4, 16'h3);
    expect_ev(K_READ, c + 5, VLO);
    expect_ev(K_READ, c + 6, VLO + 16'd1);
    expect_ev(K_LOAD, c + 6, {hi, lo});
    expect_ev(K_RUN,  c + 7, 16'h0);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    check(expq.size() == 0, "R8", "pending expected events", expq.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    // R9: power-up with pin low
    repeat (6) begin
      @(negedge clk);
      check(halt == 1'b1, "R9", "halt at power-up", halt, 1);
      check(!mem_rd && !pc_load && !set_irq_mask, "R9", "idle strobes at power-up",
            {mem_rd, pc_load, set_irq_mask}, 0);
    end

    // R4/R5/R6/R7: first release
    drive(1); c = cyc; expect_boot(c, 8'h34, 8'h12);
    settle(12);
    check(halt == 1'b0, "R7", "running after routine", halt, 0);

    // R2: one-cycle glitch while running
    drive(0); drive(1);
    settle(6);
    check(halt == 1'b0, "R2", "halt after glitch in run", halt, 0);

    // R1: two-cycle low halts
    drive(0); c = cyc; expect_ev(K_HALT, c + 2, 16'h0);
    drive(0);
    settle(5);
    check(halt == 1'b1, "R1", "halt after long low", halt, 1);

    // R6: different vector bytes
    vec_lo_byte = 8'hA5; vec_hi_byte = 8'h5A;
    drive(1); c = cyc; expect_boot(c, 8'hA5, 8'h5A);
    settle(10);

    // R1 again, then R3: glitch inside the routine
    drive(0); c = cyc; expect_ev(K_HALT, c + 2, 16'h0);
    drive(0);
    settle(4);
    vec_lo_byte = 8'h01; vec_hi_byte = 8'hC0;
    drive(1); c = cyc; expect_boot(c, 8'h01, 8'hC0);
    drive(1); drive(0); drive(1);
    settle(10);

    // R8: abort during routine, then a fresh routine
    drive(0); c = cyc; expect_ev(K_HALT, c + 2, 16'h0);
    drive(0);
    settle(4);
    drive(1);
    drive(1); drive(0); drive(0);
    settle(10);
    check(halt == 1'b1, "R8", "halt after abort", halt, 1);
    vec_lo_byte = 8'h00; vec_hi_byte = 8'hFF;
    drive(1); c = cyc; expect_boot(c, 8'h00, 8'hFF);
    settle(10);
    check(halt == 1'b0, "R8", "running after restart", halt, 0);

    finish_run();
  end
endmodule